// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory controller and its PHY from reset to a usable state without software help. A one-cycle start pulse launches a fixed script. The script opens with a settle interval. It then turns on the PHY clock, pulses PHY and calibration resets, and kicks off calibration. Next it replays the DDR2 mode-register bring-up as twelve command words written to the controller's command register. It finishes by loading the timing, latency and configuration registers, then raises a sticky done flag.

Every register action travels over one valid/ready write port that carries a 3-bit register selector and a 32-bit data word. The settle interval is a parameter counted in clock cycles. The default is 10000 cycles, which is about 200 µs at 50 MHz. The interval is inserted before the first action and after each step that needs time to take effect. The mode value, timing, latency and configuration words are also parameters.

Top module: `ddr2_init_seq`

## Requirements
- R1: After a start pulse is sampled in idle, `wr_valid` stays low for SETTLE_CYCLES cycles. The first write then goes to selector 0 (PHY configuration) with data 0x00000001, where bit 0 enables the PHY clock.
- R2: The second write goes to selector 1 (PHY control) with data 0x00000003, where bit 0 is PHY reset and bit 1 is calibration reset. It is followed at once, with no gap, by a write to selector 1 with data 0x00000004, where bit 2 is calibration start.
- R3: After the PHY configuration write, the calibration-start write and each of the twelve command writes are accepted, `wr_valid` stays low for exactly SETTLE_CYCLES cycles before the next write. Every other write follows its predecessor in the very next cycle.
- R4: Command words use selector 2. The command code sits in data bits [23:16], the argument in bits [15:0], and bits [31:24] are zero.
- R5: The twelve commands come in this order, shown as code/argument (hex): deselect 3F/0000, precharge-all 20/0400, EMRS2 12/0000, EMRS3 13/0000, EMRS 11/0000 (DLL enabled), MRS 10/0100 (DLL reset), precharge-all 20/0400, refresh 30/0000, refresh 30/0000, MRS, EMRS 11/0380 (OCD default), EMRS 11 (OCD exit).
- R6: The second MRS carries MODE_WORD[15:0]. The last EMRS carries 0x0000 (OCD exit, DLL enabled) ORed with MODE_WORD[31:16].
- R7: After the commands, three back-to-back writes follow: TIMING_WORD to selector 3, then LATENCY_WORD to selector 4, then CONFIG_WORD to selector 5.
- R8: `init_done` rises in the cycle after the configuration write is accepted and stays high until reset.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_sel` and `wr_data` hold their values.
- R10: A start pulse has no effect while a sequence is running or after `init_done` is set. No write is issued once `init_done` is high.
- R11: During synchronous reset, `wr_valid` and `init_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Write accepted in the cycle it is high with `wr_valid` |
| wr_sel | output | 3 | Target register selector |
| wr_data | output | 32 | Write data |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds two copies of the block. The first uses a 20-cycle settle interval, and its ready line is stalled by a pseudo-random pattern, so holding under back-pressure and stray start pulses are exercised in every phase while the reference model checks each cycle. The second uses the minimum interval of one cycle with ready tied high. This brings the one-cycle wait boundary and the exact handshake-to-handshake gaps within reach. The two copies use different mode words so that the split of the mode value into the MRS and EMRS arguments shows in both halves.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  localparam int STEPS = 18;

  typedef enum logic [2:0] {
    SEL_PHY_CFG  = 3'd0,
    SEL_PHY_CTRL = 3'd1,
    SEL_CMD      = 3'd2,
    SEL_TIMING   = 3'd3,
    SEL_LATENCY  = 3'd4,
    SEL_CONFIG   = 3'd5
  } reg_sel_e;

  localparam logic [7:0] CMD_MRS   = 8'h10;
  localparam logic [7:0] CMD_EMRS  = 8'h11;
  localparam logic [7:0] CMD_EMRS2 = 8'h12;
  localparam logic [7:0] CMD_EMRS3 = 8'h13;
  localparam logic [7:0] CMD_PRE   = 8'h20;
  localparam logic [7:0] CMD_REF   = 8'h30;
  localparam logic [7:0] CMD_DESEL = 8'h3F;

  localparam logic [15:0] ARG_PRE_ALL  = 16'h0400;
  localparam logic [15:0] ARG_DLL_EN   = 16'h0000;
  localparam logic [15:0] ARG_DLL_RST  = 16'h0100;
  localparam logic [15:0] ARG_OCD_DFLT = 16'h0380;
  localparam logic [15:0] ARG_OCD_EXIT = 16'h0000;

  localparam logic [31:0] PHY_CLK_EN    = 32'h0000_0001;
  localparam logic [31:0] PHY_RESETS    = 32'h0000_0003;
  localparam logic [31:0] PHY_CAL_START = 32'h0000_0004;

  typedef struct packed {
    reg_sel_e    sel;
    logic [31:0] data;
    logic        settle_after;
  } step_t;
endpackage

// File: rtl/dinit_step_rom.sv
module dinit_step_rom
  import dinit_pkg::*;
#(
  parameter logic [31:0] MODE_WORD    = 32'h0000_0000,
  parameter logic [31:0] TIMING_WORD  = 32'h0000_0000,
  parameter logic [31:0] LATENCY_WORD = 32'h0000_0000,
  parameter logic [31:0] CONFIG_WORD  = 32'h0000_0000,
  parameter int          IDX_W        = 5
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            step
);
  function automatic step_t mk(reg_sel_e s, logic [31:0] d, logic w);
    step_t r;
    r.sel          = s;
    r.data         = d;
    r.settle_after = w;
    return r;
  endfunction

  function automatic step_t cmd(logic [7:0] code, logic [15:0] arg);
    return mk(SEL_CMD, {8'h00, code, arg}, 1'b1);
  endfunction

  int unsigned pos;
  assign pos = 32'(idx);

  always_comb begin
    case (pos)
      0:       step = mk(SEL_PHY_CFG, PHY_CLK_EN, 1'b1);
      1:       step = mk(SEL_PHY_CTRL, PHY_RESETS, 1'b0);
      2:       step = mk(SEL_PHY_CTRL, PHY_CAL_START, 1'b1);
      3:       step = cmd(CMD_DESEL, 16'h0000);
      4:       step = cmd(CMD_PRE, ARG_PRE_ALL);
      5:       step = cmd(CMD_EMRS2, 16'h0000);
      6:       step = cmd(CMD_EMRS3, 16'h0000);
      7:       step = cmd(CMD_EMRS, ARG_DLL_EN);
      8:       step = cmd(CMD_MRS, ARG_DLL_RST);
      9:       step = cmd(CMD_PRE, ARG_PRE_ALL);
      10, 11:  step = cmd(CMD_REF, 16'h0000);
      12:      step = cmd(CMD_MRS, MODE_WORD[15:0]);
      13:      step = cmd(CMD_EMRS, ARG_OCD_DFLT | ARG_DLL_EN);
      14:      step = cmd(CMD_EMRS, ARG_OCD_EXIT | ARG_DLL_EN | MODE_WORD[31:16]);
      15:      step = mk(SEL_TIMING, TIMING_WORD, 1'b0);
      16:      step = mk(SEL_LATENCY, LATENCY_WORD, 1'b0);
      17:      step = mk(SEL_CONFIG, CONFIG_WORD, 1'b0);
      default: step = mk(SEL_PHY_CFG, 32'h0, 1'b0);
    endcase
  end
endmodule

// File: rtl/dinit_settle_timer.sv
module dinit_settle_timer #(
  parameter int SETTLE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= RELOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import dinit_pkg::*;
#(
  parameter int          SETTLE_CYCLES = 10000,
  parameter logic [31:0] MODE_WORD     = 32'h0004_0A42,
  parameter logic [31:0] TIMING_WORD   = 32'h2236_1A0C,
  parameter logic [31:0] LATENCY_WORD  = 32'h0000_0305,
  parameter logic [31:0] CONFIG_WORD   = 32'h0001_0021
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [2:0]  wr_sel,
  output logic [31:0] wr_data,
  output logic        init_done
);
  localparam int IDX_W = $clog2(STEPS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_WRITE, ST_DONE} state_e;

  state_e           state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rom_idx;
  logic             settle_q;
  logic             timer_load;
  logic             timer_expired;
  logic             accept;
  step_t            step;

  assign accept     = (state == ST_WRITE) && wr_ready;
  assign rom_idx    = (state == ST_WRITE) ? idx + 1'b1 : idx;
  assign timer_load = ((state == ST_IDLE) && start) ||
                      (accept && settle_q && (idx != LAST_IDX));

  dinit_step_rom #(
    .MODE_WORD   (MODE_WORD),
    .TIMING_WORD (TIMING_WORD),
    .LATENCY_WORD(LATENCY_WORD),
    .CONFIG_WORD (CONFIG_WORD),
    .IDX_W       (IDX_W)
  ) u_rom (
    .idx (rom_idx),
    .step(step)
  );

  dinit_settle_timer #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (timer_load),
    .expired(timer_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      settle_q  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_sel    <= 3'd0;
      wr_data   <= 32'h0;
      init_done <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (timer_expired) begin
            state    <= ST_WRITE;
            wr_valid <= 1'b1;
            wr_sel   <= step.sel;
            wr_data  <= step.data;
            settle_q <= step.settle_after;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            if (idx == LAST_IDX) begin
              state     <= ST_DONE;
              wr_valid  <= 1'b0;
              init_done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              if (settle_q) begin
                state    <= ST_WAIT;
                wr_valid <= 1'b0;
              end else begin
                wr_sel   <= step.sel;
                wr_data  <= step.data;
                settle_q <= step.settle_after;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dinit_checker.sv
module dinit_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        init_done
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_sel) && $stable(wr_data))); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R8

  AST_DONE_AFTER_CONFIG: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> $past(wr_valid && wr_ready && (wr_sel == 3'd5))); // R8

  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    init_done |-> !wr_valid); // R10

  AST_CMD_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && (wr_sel == 3'd2)) |-> (wr_data[31:24] == 8'h00)); // R4

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_sel <= 3'd5)); // R4
endmodule

bind ddr2_init_seq dinit_checker u_dinit_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .init_done(init_done)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;
  localparam int S_MAIN = 20;
  localparam int S_MIN  = 1;
  localparam logic [31:0] MODE_A = 32'hA5C3_1234;
  localparam logic [31:0] MODE_B = 32'h0F0F_F0F0;
  localparam logic [31:0] TIM_A = 32'h1111_2222, LAT_A = 32'h0000_0033, CFG_A = 32'h8000_0005;
  localparam logic [31:0] TIM_B = 32'h3344_5566, LAT_B = 32'h0000_0707, CFG_B = 32'h0000_00C1;
  localparam int NW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ready = 1'b1;
  logic [7:0] lfsr = 8'hB7;
  int cyc = 0;
  int tests = 0;
  int fails = 0;

  logic        a_valid, a_done, b_valid, b_done;
  logic [2:0]  a_sel, b_sel;
  logic [31:0] a_data, b_data;

  always #4 clk = ~clk;

  ddr2_init_seq #(.SETTLE_CYCLES(S_MAIN), .MODE_WORD(MODE_A), .TIMING_WORD(TIM_A),
                  .LATENCY_WORD(LAT_A), .CONFIG_WORD(CFG_A)) dut_i (
    .clk(clk), .rst(rst), .start(start), .wr_valid(a_valid), .wr_ready(ready),
    .wr_sel(a_sel), .wr_data(a_data), .init_done(a_done));

  ddr2_init_seq #(.SETTLE_CYCLES(S_MIN), .MODE_WORD(MODE_B), .TIMING_WORD(TIM_B),
                  .LATENCY_WORD(LAT_B), .CONFIG_WORD(CFG_B)) dut_min_i (
    .clk(clk), .rst(rst), .start(start), .wr_valid(b_valid), .wr_ready(1'b1),
    .wr_sel(b_sel), .wr_data(b_data), .init_done(b_done));

  // Expected write: {settle_after, sel[2:0], data[31:0]}
  function automatic logic [35:0] exp_w(int i, logic [31:0] m, logic [31:0] t,
                                        logic [31:0] l, logic [31:0] c);
    case (i)
      0:  return {1'b1, 3'd0, 32'h1};
      1:  return {1'b0, 3'd1, 32'h3};
      2:  return {1'b1, 3'd1, 32'h4};
      3:  return {1'b1, 3'd2, 32'h003F_0000};
      4:  return {1'b1, 3'd2, 32'h0020_0400};
      5:  return {1'b1, 3'd2, 32'h0012_0000};
      6:  return {1'b1, 3'd2, 32'h0013_0000};
      7:  return {1'b1, 3'd2, 32'h0011_0000};
      8:  return {1'b1, 3'd2, 32'h0010_0100};
      9:  return {1'b1, 3'd2, 32'h0020_0400};
      10: return {1'b1, 3'd2, 32'h0030_0000};
      11: return {1'b1, 3'd2, 32'h0030_0000};
      12: return {1'b1, 3'd2, 16'h0010, m[15:0]};
      13: return {1'b1, 3'd2, 32'h0011_0380};
      14: return {1'b1, 3'd2, 16'h0011, m[31:16]};
      15: return {1'b0, 3'd3, t};
      16: return {1'b0, 3'd4, l};
      default: return {1'b0, 3'd5, c};
    endcase
  endfunction

  function automatic string step_tag(int i);
    if (i == 0) return "R1";
    if (i < 3) return "R2";
    if (i == 12 || i == 14) return "R6";
    if (i < 15) return "R5";
    return "R7";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model for dut_i
  bit m_busy = 0, m_done = 0;
  int m_wait = 0, m_idx = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_busy = 0; m_done = 0; m_wait = 0; m_idx = 0;
    end else if (!m_busy && !m_done) begin
      if (start) begin m_busy = 1; m_wait = S_MAIN; end
    end else if (m_busy) begin
      if (m_wait > 0) m_wait--;
      else if (ready) begin
        if (m_idx == NW - 1) begin m_busy = 0; m_done = 1; end
        else begin
          if (exp_w(m_idx, MODE_A, TIM_A, LAT_A, CFG_A)[35]) m_wait = S_MAIN;
          m_idx++;
        end
      end
    end
    #1 lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ready <= (lfsr[1:0] != 2'b00);
  end

  // Per-cycle comparison against the model, away from the active edge
  int a_writes = 0;
  bit a_hold = 0;
  logic [34:0] a_held;
  always @(negedge clk) begin
    if (!rst) begin
      logic [35:0] e;
      bit ev;
      e  = exp_w(m_idx, MODE_A, TIM_A, LAT_A, CFG_A);
      ev = m_busy && (m_wait == 0);
      chk(a_valid == ev, "R3", "wr_valid timing", 64'(a_valid), 64'(ev));
      chk(a_done == m_done, "R8", "init_done", 64'(a_done), 64'(m_done));
      if (ev && a_valid) begin
        chk(a_sel == e[34:32], step_tag(m_idx), "selector", 64'(a_sel), 64'(e[34:32]));
        chk(a_data == e[31:0], step_tag(m_idx), "data", 64'(a_data), 64'(e[31:0]));
      end
      if (a_hold)
        chk(a_valid && ({a_sel, a_data} == a_held), "R9", "hold under stall",
            64'({a_sel, a_data}), 64'(a_held));
      a_hold = a_valid && !ready;
      a_held = {a_sel, a_data};
      if (a_valid && ready) a_writes++;
      if (a_done && a_valid) chk(0, "R10", "write after done", 64'(1), 64'(0));
    end
  end

  // Capture for dut_min_i (always ready)
  int b_n = 0, b_start_c = -1, b_done_c = -1;
  int b_cyc[NW];
  logic [34:0] b_w[NW];
  always @(negedge clk) begin
    if (!rst) begin
      if (start && b_start_c < 0) b_start_c = cyc;
      if (b_valid) begin
        if (b_n < NW) begin b_cyc[b_n] = cyc; b_w[b_n] = {b_sel, b_data}; end
        b_n++;
      end
      if (b_done && b_done_c < 0) b_done_c = cyc;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!a_valid && !b_valid, "R11", "valid in reset", 64'({a_valid, b_valid}), 64'(0));
    chk(!a_done && !b_done, "R11", "done in reset", 64'({a_done, b_done}), 64'(0));
    @(posedge clk); #1 rst = 1'b0;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (12) @(posedge clk);
    #1 start = 1'b1;                                     // R10 while busy
    @(posedge clk); #1 start = 1'b0;
    repeat (5 * S_MAIN) @(posedge clk);
    #1 start = 1'b1;                                     // R10 while busy, later phase
    @(posedge clk); #1 start = 1'b0;
    wait (m_done && b_done);
    repeat (4) @(posedge clk);
    #1 start = 1'b1;                                     // R10 after done
    @(posedge clk); #1 start = 1'b0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(a_writes == NW, "R5", "write count (stalled copy)", 64'(a_writes), 64'(NW));
    chk(b_n == NW, "R5", "write count (min copy)", 64'(b_n), 64'(NW));
    chk(a_done && b_done, "R8", "done held", 64'({a_done, b_done}), 64'(3));
    if (b_n == NW) begin
      chk(b_cyc[0] - b_start_c == S_MIN + 1, "R1", "start to first write",
          64'(b_cyc[0] - b_start_c), 64'(S_MIN + 1));
      for (int i = 0; i < NW; i++) begin
        logic [35:0] e;
        e = exp_w(i, MODE_B, TIM_B, LAT_B, CFG_B);
        chk(b_w[i] == e[34:0], step_tag(i), "min copy write", 64'(b_w[i]), 64'(e[34:0]));
        if (e[34:32] == 3'd2)
          chk(b_w[i][31:24] == 8'h00, "R4", "command top byte", 64'(b_w[i][31:24]), 64'(0));
        if (i > 0) begin
          int g;
          g = exp_w(i - 1, MODE_B, TIM_B, LAT_B, CFG_B)[35] ? S_MIN + 1 : 1;
          chk(b_cyc[i] - b_cyc[i-1] == g, "R3", "handshake gap",
              64'(b_cyc[i] - b_cyc[i-1]), 64'(g));
        end
      end
      chk(b_done_c - b_cyc[NW-1] == 1, "R8", "done after config write",
          64'(b_done_c - b_cyc[NW-1]), 64'(1));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule